// File: doc/BRIEF.md
# Windowed Overlay Alpha Blender

This block lays one layer of pixels over a background, but only inside a rectangular window on the output raster. Each cycle it takes a raster position, a layer pixel with an optional alpha byte, and the background pixel at that position. It returns the composited pixel a fixed number of cycles later. The position and a valid flag come out with it, delayed by the same amount.

The window is set by two corner words, and both corners are inclusive. The alpha mode is not programmed directly. The block derives it from two things: whether the configured layer format carries per-pixel alpha, and whether the global alpha is below full scale. The three possible results are global alpha only, per-pixel alpha only, or the rounded product of the two. When the channel is disabled, or the pixel lies outside the window, the background passes through unchanged.

Top module: `ovl_blend`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `out_pix` is all zeros.
- R2: Latency is exactly 3 clock edges. A sample presented with `in_valid` = 1 appears on `out_valid`, `out_x` and `out_y` three edges later. A new sample is accepted on every cycle.
- R3: A pixel is inside the window when x0 <= x <= x1 and y0 <= y <= y1, so all four corner coordinates are inclusive. In `cfg_start` (x0, y0) and `cfg_end` (x1, y1), x occupies bits [2*XW-1:XW] and y occupies bits [XW-1:0].
- R4: For a pixel outside the window, `out_pix` equals the background pixel exactly.
- R5: When `cfg_en` = 0, `out_pix` equals the background pixel at every position.
- R6: Format codes are 0 RGB565, 1 BGR565, 2 RGB888, 3 BGR888, 4 XRGB8888, 5 XBGR8888, 6 RGBA8888, 7 BGRA8888, 8 ARGB8888 and 9 ABGR8888. Only codes 6 to 9 carry per-pixel alpha. With such a format and `cfg_galpha` = 255, the mode is per-pixel (`out_mode` = 1) and a = `lyr_alpha`.
- R7: With an alpha-bearing format and `cfg_galpha` < 255, the mode is combined (`out_mode` = 2) and a = (`lyr_alpha` * `cfg_galpha` + 127) / 255.
- R8: With any format code other than 6 to 9 (including unused codes 10 to 15), the mode is global (`out_mode` = 0) and a = `cfg_galpha`. In this mode `lyr_alpha` has no effect.
- R9: Inside the window, each 8-bit component is (a*L + (255-a)*B + 127) / 255, where L is the layer component and B is the background component. Component 0 occupies the low bits of the pixel word.
- R10: `out_mode` reports the mode derived from the configuration for every valid output, whether the pixel is inside or outside the window, and never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_x | input | XW | Raster column of the sample |
| in_y | input | XW | Raster row of the sample |
| lyr_pix | input | 3*CW | Layer pixel, component 0 in the low bits |
| lyr_alpha | input | CW | Per-pixel layer alpha |
| bg_pix | input | 3*CW | Background pixel |
| cfg_start | input | 2*XW | Window start corner, x in upper field, y in lower field |
| cfg_end | input | 2*XW | Window end corner, inclusive, same layout |
| cfg_en | input | 1 | Channel enable |
| cfg_galpha | input | CW | Global alpha |
| cfg_fmt | input | 4 | Layer format code |
| out_valid | output | 1 | Output sample valid |
| out_x | output | XW | Delayed column |
| out_y | output | XW | Delayed row |
| out_pix | output | 3*CW | Composited pixel |
| out_mode | output | 2 | Alpha mode: 0 global, 1 per-pixel, 2 combined |

## Verification
Several properties are checked on every valid output:
- the reported mode matches the format and global alpha that were applied three cycles earlier;
- the mode never takes the unused value 3;
- position and valid travel through the pipeline with exactly three cycles of delay;
- a disabled channel, or a pixel to the left of the window start, yields the background exactly.

Some behaviour can only be shown by the bench's scenarios:
- the arithmetic of the blend and of the combined alpha, with its rounding;
- the inclusive treatment of all four window edges;
- that pixel alpha is ignored for formats without alpha;
- one-sample-per-cycle throughput.

// File: rtl/ovl_blend.sv
module ovl_blend #(
  parameter int XW = 12,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [XW-1:0]     in_x,
  input  logic [XW-1:0]     in_y,
  input  logic [3*CW-1:0]   lyr_pix,
  input  logic [CW-1:0]     lyr_alpha,
  input  logic [3*CW-1:0]   bg_pix,
  input  logic [2*XW-1:0]   cfg_start,
  input  logic [2*XW-1:0]   cfg_end,
  input  logic              cfg_en,
  input  logic [CW-1:0]     cfg_galpha,
  input  logic [3:0]        cfg_fmt,
  output logic              out_valid,
  output logic [XW-1:0]     out_x,
  output logic [XW-1:0]     out_y,
  output logic [3*CW-1:0]   out_pix,
  output logic [1:0]        out_mode
);
  localparam int NC = 3;
  localparam int PW = NC * CW;
  localparam int SW = 2 * CW;
  localparam logic [CW-1:0] FULL = {CW{1'b1}};
  localparam logic [1:0] M_GLB = 2'd0;
  localparam logic [1:0] M_PIX = 2'd1;
  localparam logic [1:0] M_MIX = 2'd2;

  function automatic logic [CW-1:0] div_full(input logic [SW-1:0] v);
    logic [SW:0] t;
    logic [SW:0] r;
    t = {1'b0, v} + (SW+1)'(1 << (CW - 1));
    r = (t + (t >> CW)) >> CW;
    return r[CW-1:0];
  endfunction

  wire [XW-1:0] wx0 = cfg_start[2*XW-1:XW];
  wire [XW-1:0] wy0 = cfg_start[XW-1:0];
  wire [XW-1:0] wx1 = cfg_end[2*XW-1:XW];
  wire [XW-1:0] wy1 = cfg_end[XW-1:0];

  wire has_a = (cfg_fmt >= 4'd6) && (cfg_fmt <= 4'd9);
  wire [1:0] mode_c = !has_a ? M_GLB : (cfg_galpha == FULL) ? M_PIX : M_MIX;
  wire [SW-1:0] prod = lyr_alpha * cfg_galpha;
  wire [CW-1:0] mix_a = div_full(prod);
  wire [CW-1:0] a_c = (mode_c == M_GLB) ? cfg_galpha :
                      (mode_c == M_PIX) ? lyr_alpha : mix_a;
  wire hit = cfg_en && (in_x >= wx0) && (in_x <= wx1) &&
             (in_y >= wy0) && (in_y <= wy1);

  logic          v1, v2;
  logic [XW-1:0] x1, y1, x2, y2;
  logic [1:0]    m1, m2;
  logic [CW-1:0] a1;
  logic [PW-1:0] l1, b1;
  logic [NC*SW-1:0] s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; x1 <= '0; y1 <= '0; m1 <= M_GLB; a1 <= '0; l1 <= '0; b1 <= '0;
      v2 <= 1'b0; x2 <= '0; y2 <= '0; m2 <= M_GLB;
      out_valid <= 1'b0; out_x <= '0; out_y <= '0; out_mode <= M_GLB;
    end else begin
      v1 <= in_valid; x1 <= in_x; y1 <= in_y; m1 <= mode_c;
      a1 <= hit ? a_c : '0;
      l1 <= lyr_pix; b1 <= bg_pix;
      v2 <= v1; x2 <= x1; y2 <= y1; m2 <= m1;
      out_valid <= v2; out_x <= x2; out_y <= y2; out_mode <= m2;
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_comp
    wire [CW-1:0] lc = l1[i*CW +: CW];
    wire [CW-1:0] bc = b1[i*CW +: CW];
    wire [SW-1:0] sum = lc * a1 + bc * (FULL - a1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s2[i*SW +: SW] <= '0;
        out_pix[i*CW +: CW] <= '0;
      end else begin
        s2[i*SW +: SW] <= sum;
        out_pix[i*CW +: CW] <= div_full(s2[i*SW +: SW]);
      end
    end
  end
endmodule

module ovl_blend_chk #(
  parameter int XW = 12,
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [XW-1:0]   in_x,
  input logic [XW-1:0]   in_y,
  input logic [3*CW-1:0] bg_pix,
  input logic [2*XW-1:0] cfg_start,
  input logic            cfg_en,
  input logic [CW-1:0]   cfg_galpha,
  input logic [3:0]      cfg_fmt,
  input logic            out_valid,
  input logic [XW-1:0]   out_x,
  input logic [XW-1:0]   out_y,
  input logic [3*CW-1:0] out_pix,
  input logic [1:0]      out_mode
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !out_valid && out_pix == '0); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3)); // R2
  AST_POS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_x == $past(in_x, 3)) && (out_y == $past(in_y, 3))); // R2
  AST_LEFT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ($past(in_x, 3) < $past(cfg_start[2*XW-1:XW], 3)) |-> out_pix == $past(bg_pix, 3)); // R4
  AST_DISABLED_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(cfg_en, 3) |-> out_pix == $past(bg_pix, 3)); // R5
  AST_MODE_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ($past(cfg_fmt, 3) inside {[4'd6:4'd9]}) && ($past(cfg_galpha, 3) == {CW{1'b1}})
    |-> out_mode == 2'd1); // R6
  AST_MODE_COMBINED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ($past(cfg_fmt, 3) inside {[4'd6:4'd9]}) && ($past(cfg_galpha, 3) != {CW{1'b1}})
    |-> out_mode == 2'd2); // R7
  AST_MODE_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !($past(cfg_fmt, 3) inside {[4'd6:4'd9]}) |-> out_mode == 2'd0); // R8
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mode != 2'd3); // R10
endmodule

bind ovl_blend ovl_blend_chk #(.XW(XW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
  .bg_pix(bg_pix), .cfg_start(cfg_start), .cfg_en(cfg_en),
  .cfg_galpha(cfg_galpha), .cfg_fmt(cfg_fmt), .out_valid(out_valid),
  .out_x(out_x), .out_y(out_y), .out_pix(out_pix), .out_mode(out_mode));

// File: tb/ovl_blend_tb.sv
module ovl_blend_tb_top;
  localparam int PERIOD = 10;
  localparam int XW = 12;
  localparam int CW = 8;

  typedef struct packed {
    logic [11:0] x;
    logic [11:0] y;
    logic [23:0] lp;
    logic [7:0]  la;
    logic [23:0] bg;
    logic [3:0]  fmt;
    logic [7:0]  ga;
    logic        en;
    logic [1:0]  emode;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{12'd10, 12'd20, 24'hFF8000, 8'd200, 24'h102030, 4'd8,  8'd255, 1'b1, 2'd1}, // R3 start corner, R6
    '{12'd13, 12'd22, 24'h00FF40, 8'd180, 24'h804020, 4'd6,  8'd128, 1'b1, 2'd2}, // R3 end corner, R7
    '{12'd9,  12'd20, 24'hFFFFFF, 8'd255, 24'h123456, 4'd8,  8'd255, 1'b1, 2'd1}, // R4 left
    '{12'd14, 12'd21, 24'hFFFFFF, 8'd255, 24'h654321, 4'd4,  8'd200, 1'b1, 2'd0}, // R4 right
    '{12'd11, 12'd19, 24'hFFFFFF, 8'd255, 24'hABCDEF, 4'd7,  8'd255, 1'b1, 2'd1}, // R4 above
    '{12'd11, 12'd23, 24'hFFFFFF, 8'd255, 24'h0F0F0F, 4'd9,  8'd10,  1'b1, 2'd2}, // R4 below
    '{12'd12, 12'd21, 24'hC86432, 8'd0,   24'h203040, 4'd2,  8'd100, 1'b1, 2'd0}, // R8 alpha ignored
    '{12'd12, 12'd21, 24'h5A5A5A, 8'd0,   24'hA5A5A5, 4'd0,  8'd255, 1'b1, 2'd0}, // R8 opaque
    '{12'd12, 12'd21, 24'hFFFFFF, 8'd255, 24'h336699, 4'd9,  8'd0,   1'b1, 2'd2}, // R7 zero global
    '{12'd10, 12'd22, 24'h77EE11, 8'd255, 24'h000000, 4'd7,  8'd255, 1'b1, 2'd1}, // R6 full pixel
    '{12'd11, 12'd21, 24'h90A0B0, 8'd30,  24'h102030, 4'd12, 8'd50,  1'b1, 2'd0}, // R8 unused code
    '{12'd11, 12'd21, 24'hFFFFFF, 8'd255, 24'h445566, 4'd8,  8'd255, 1'b0, 2'd1}  // R5 disabled
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [XW-1:0] in_x = '0, in_y = '0;
  logic [3*CW-1:0] lyr_pix = '0, bg_pix = '0;
  logic [CW-1:0] lyr_alpha = '0, cfg_galpha = '0;
  logic [2*XW-1:0] cfg_start = '0, cfg_end = '0;
  logic cfg_en = 1'b0;
  logic [3:0] cfg_fmt = '0;
  logic out_valid;
  logic [XW-1:0] out_x, out_y;
  logic [3*CW-1:0] out_pix;
  logic [1:0] out_mode;
  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  ovl_blend #(.XW(XW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .lyr_pix(lyr_pix), .lyr_alpha(lyr_alpha), .bg_pix(bg_pix),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_en(cfg_en),
    .cfg_galpha(cfg_galpha), .cfg_fmt(cfg_fmt), .out_valid(out_valid),
    .out_x(out_x), .out_y(out_y), .out_pix(out_pix), .out_mode(out_mode));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input vec_t v);
    int a;
    logic [23:0] r;
    bit inside_w;
    inside_w = v.en && v.x >= 10 && v.x <= 13 && v.y >= 20 && v.y <= 22;
    if (v.fmt >= 6 && v.fmt <= 9)
      a = (v.ga == 255) ? int'(v.la) : (int'(v.la) * int'(v.ga) + 127) / 255;
    else
      a = v.ga;
    if (!inside_w) a = 0;
    for (int i = 0; i < 3; i++)
      r[i*8 +: 8] = 8'((a * int'(v.lp[i*8 +: 8]) + (255 - a) * int'(v.bg[i*8 +: 8]) + 127) / 255);
    return r;
  endfunction

  task automatic drive(input vec_t v, input logic vld);
    in_valid = vld; in_x = v.x; in_y = v.y; lyr_pix = v.lp; lyr_alpha = v.la;
    bg_pix = v.bg; cfg_fmt = v.fmt; cfg_galpha = v.ga; cfg_en = v.en;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cfg_start = {12'd10, 12'd20};
    cfg_end   = {12'd13, 12'd22};
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1 pix in reset", {8'd0, out_pix}, 32'd0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {31'd0, out_valid}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VEC[k];
      @(negedge clk); drive(v, 1'b1);
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      check("R2 valid before latency", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      check("R2 valid", {31'd0, out_valid}, 32'd1);
      check("R9/R4/R5 pixel", {8'd0, out_pix}, {8'd0, model(v)});
      check("R10 mode", {30'd0, out_mode}, {30'd0, v.emode});
      check("R2 position", {8'd0, out_x, out_y}, {8'd0, v.x, v.y});
    end

    // R2 back-to-back stream, opaque global mode so output equals layer
    for (int t = 0; t < 6; t++) begin
      vec_t s;
      @(negedge clk);
      if (t == 2) check("R2 no early output", {31'd0, out_valid}, 32'd0);
      if (t >= 3) begin
        check("R2 stream valid", {31'd0, out_valid}, 32'd1);
        check("R2 stream x", {20'd0, out_x}, 32'(10 + t - 3));
        check("R9 stream pixel", {8'd0, out_pix}, {8'd0, 24'h111111 * 24'(t - 2)});
      end
      s = '{12'(10 + t), 12'd21, 24'h111111 * 24'(t + 1), 8'd0, 24'hFFFFFF, 4'd4, 8'd255, 1'b1, 2'd0};
      drive(s, t < 3);
    end

    // R1 reset mid-stream clears output
    @(negedge clk);
    drive(VEC[0], 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-stream valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset mid-stream pix", {8'd0, out_pix}, 32'd0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 no stale output", {31'd0, out_valid}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule